// File: doc/BRIEF.md
# Run-Time Programmable Probe Trigger Unit

This block watches several probe buses that are sampled on the monitored design clock. It raises a single registered trigger when the probes meet a condition that is loaded at run time. Each probe bus has its own comparator. A comparator either matches every bit against a 3-bit code, or compares the whole bus as an unsigned number against a reference value. A bit code can ask for a level (0 or 1), accept any value, or ask for a change measured against the sample taken one cycle earlier (rise, fall, any change, no change). The comparator can then report the pattern result directly or report its inverse.

A combiner takes the comparator results. It requires either all of them or any one of them, as chosen at run time, and registers the result as the trigger. Configuration arrives one word per clock through a write port. Each write names a comparator and a kind of field. While a write is taking effect, the trigger is held low until a fresh previous sample exists again.

Top module: `probe_trigger_unit`

## Requirements
- R1: With operator code 0 (equal), a comparator matches when every bit satisfies its code. The code for bit i sits in cfg bits [3i+2:3i]. Code 0 needs the bit at 0, code 1 needs it at 1, and codes 2 and 7 accept any value.
- R2: The edge codes compare the current sample with the sample from one cycle earlier. Code 3 needs a 0 to 1 change, code 4 a 1 to 0 change, code 5 any change, and code 6 no change.
- R3: Operator code 1 (not equal) matches exactly when the R1/R2 pattern result is false, and this includes edge-coded bits.
- R4: Operator codes 2 (greater), 3 (less), 4 (greater or equal) and 5 (less or equal) compare the probe as an unsigned number with the reference value. In these modes the bit codes have no effect.
- R5: Operator codes 6 and 7 never match.
- R6: A combine write (kind 3) selects the mode from data bit 0. A value of 1 requires every comparator to match (AND). A value of 0 requires at least one comparator to match (OR).
- R7: The trigger is a register. After a clock edge, it reflects the probe values that were present before that edge and the values from the edge before.
- R8: After an edge at which cfg_we_i is high, the trigger is low, and it stays low after the following edge too. The first edge after reset also gives a low trigger.
- R9: Reset sets every operator to code 7, every bit code to 2, every reference value to 0 and the combine mode to OR, so the trigger stays low.
- R10: Write kinds are 0 for the operator (data bits [2:0]), 1 for the bit codes, 2 for the reference value (low bits) and 3 for the combine mode. Kinds 0 to 2 act only on the comparator named by cfg_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored design clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | NUM_CMP*PROBE_W | Probe buses; comparator c uses slice [c*PROBE_W +: PROBE_W] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Comparator selected by the write |
| cfg_kind_i | input | 2 | Field selected by the write |
| cfg_data_i | input | 3*PROBE_W | Write data |
| trigger_o | output | 1 | Registered trigger event |

## Verification
The level pattern is tested with probes that violate a single fixed-level bit, which separates a real compare from a don't-care bit. Each edge code is driven through rise, hold and fall sequences, so that codes 3 to 6 can be told apart. The not-equal mode is tested on the same edge-qualified pattern, which checks that the edge bits are part of the inversion.

The magnitude tests use probes one below, equal to and one above the reference value, plus a value with the top bit set that a signed compare would order wrongly. The bit codes are set to all-zero during these tests to show that they have no effect. In the combine tests, one comparator is always true, so AND and OR give different results, and the blanking after a write is checked while the condition would otherwise fire.

// File: rtl/trig_cmp_pkg.sv
package trig_cmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_GT  = 3'd2,
        OP_LT  = 3'd3,
        OP_GE  = 3'd4,
        OP_LE  = 3'd5,
        OP_RSV = 3'd6,
        OP_OFF = 3'd7
    } cmp_op_e;

    typedef enum logic [2:0] {
        BC_ZERO   = 3'd0,
        BC_ONE    = 3'd1,
        BC_ANY    = 3'd2,
        BC_RISE   = 3'd3,
        BC_FALL   = 3'd4,
        BC_CHANGE = 3'd5,
        BC_STEADY = 3'd6,
        BC_SPARE  = 3'd7
    } bit_code_e;

    typedef enum logic [1:0] {
        CK_OP    = 2'd0,
        CK_CODES = 2'd1,
        CK_REF   = 2'd2,
        CK_COMB  = 2'd3
    } cfg_kind_e;

    // Qualifies one probe bit given its code, current and previous value.
    function automatic logic bit_ok(input logic [2:0] code,
                                    input logic cur, input logic old);
        logic ok;
        case (code)
            BC_ZERO:   ok = ~cur;
            BC_ONE:    ok = cur;
            BC_RISE:   ok = ~old & cur;
            BC_FALL:   ok = old & ~cur;
            BC_CHANGE: ok = old ^ cur;
            BC_STEADY: ok = ~(old ^ cur);
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_cmp_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int PROBE_W = 8,
    parameter int IDX_W   = 1,
    parameter int CFG_W   = 3 * PROBE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [1:0]                        kind_i,
    input  logic [CFG_W-1:0]                  data_i,
    output logic [NUM_CMP-1:0][2:0]           op_o,
    output logic [NUM_CMP-1:0][CFG_W-1:0]     codes_o,
    output logic [NUM_CMP-1:0][PROBE_W-1:0]   ref_o,
    output logic                              and_mode_o
);

    typedef struct packed {
        logic [NUM_CMP-1:0][2:0]         op;
        logic [NUM_CMP-1:0][CFG_W-1:0]   codes;
        logic [NUM_CMP-1:0][PROBE_W-1:0] refv;
        logic                            and_mode;
    } bank_t;

    localparam logic [CFG_W-1:0] CODES_RST = {PROBE_W{BC_ANY}};

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            if (kind_i == CK_COMB) begin
                bank_d.and_mode = data_i[0];
            end
            for (int c = 0; c < NUM_CMP; c++) begin
                if (idx_i == IDX_W'(c)) begin
                    case (kind_i)
                        CK_OP:    bank_d.op[c]    = data_i[2:0];
                        CK_CODES: bank_d.codes[c] = data_i;
                        CK_REF:   bank_d.refv[c]  = data_i[PROBE_W-1:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CMP; c++) begin
                bank_q.op[c]    <= OP_OFF;
                bank_q.codes[c] <= CODES_RST;
                bank_q.refv[c]  <= '0;
            end
            bank_q.and_mode <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign op_o       = bank_q.op;
    assign codes_o    = bank_q.codes;
    assign ref_o      = bank_q.refv;
    assign and_mode_o = bank_q.and_mode;

endmodule

// File: rtl/probe_cmp.sv
module probe_cmp
    import trig_cmp_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int CFG_W   = 3 * PROBE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_i,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic [2:0]         op_i,
    input  logic [CFG_W-1:0]   codes_i,
    input  logic [PROBE_W-1:0] ref_i,
    output logic               match_o
);

    typedef struct packed {
        logic [PROBE_W-1:0] prev;
        logic               valid;
    } hist_t;

    hist_t hist_d, hist_q;
    logic [PROBE_W-1:0] bit_hit;
    logic pattern_hit;
    logic raw_match;

    for (genvar i = 0; i < PROBE_W; i++) begin : g_bit
        assign bit_hit[i] = bit_ok(codes_i[3*i +: 3], probe_i[i], hist_q.prev[i]);
    end

    assign pattern_hit = &bit_hit;

    always_comb begin
        hist_d.prev  = probe_i;
        hist_d.valid = ~hold_i;
        case (op_i)
            OP_EQ:   raw_match = pattern_hit;
            OP_NE:   raw_match = ~pattern_hit;
            OP_GT:   raw_match = probe_i >  ref_i;
            OP_LT:   raw_match = probe_i <  ref_i;
            OP_GE:   raw_match = probe_i >= ref_i;
            OP_LE:   raw_match = probe_i <= ref_i;
            default: raw_match = 1'b0;
        endcase
    end

    assign match_o = raw_match & hist_q.valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assert_reserved_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSV || op_i == OP_OFF) |-> !match_o);

    assert_history_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !match_o);

endmodule

// File: rtl/trig_combine.sv
module trig_combine #(
    parameter int NUM_CMP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_i,
    input  logic               and_mode_i,
    input  logic [NUM_CMP-1:0] match_i,
    output logic               trig_o
);

    typedef struct packed {
        logic trig;
    } comb_t;

    comb_t comb_d, comb_q;

    always_comb begin
        comb_d.trig = ~hold_i & (and_mode_i ? (&match_i) : (|match_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_q <= '0;
        end else begin
            comb_q <= comb_d;
        end
    end

    assign trig_o = comb_q.trig;

    assert_and_needs_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(and_mode_i)) |-> $past(&match_i));

    assert_or_needs_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !$past(and_mode_i)) |-> $past(|match_i));

endmodule

// File: rtl/probe_trigger_unit.sv
module probe_trigger_unit
    import trig_cmp_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int PROBE_W = 8,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
    localparam int CFG_W  = 3 * PROBE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CMP*PROBE_W-1:0] probe_i,
    input  logic                       cfg_we_i,
    input  logic [IDX_W-1:0]           cfg_idx_i,
    input  logic [1:0]                 cfg_kind_i,
    input  logic [CFG_W-1:0]           cfg_data_i,
    output logic                       trigger_o
);

    logic [NUM_CMP-1:0][2:0]         op_w;
    logic [NUM_CMP-1:0][CFG_W-1:0]   codes_w;
    logic [NUM_CMP-1:0][PROBE_W-1:0] ref_w;
    logic                            and_mode_w;
    logic [NUM_CMP-1:0]              match_w;

    trig_cfg_bank #(
        .NUM_CMP (NUM_CMP),
        .PROBE_W (PROBE_W),
        .IDX_W   (IDX_W),
        .CFG_W   (CFG_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .idx_i      (cfg_idx_i),
        .kind_i     (cfg_kind_i),
        .data_i     (cfg_data_i),
        .op_o       (op_w),
        .codes_o    (codes_w),
        .ref_o      (ref_w),
        .and_mode_o (and_mode_w)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        probe_cmp #(
            .PROBE_W (PROBE_W),
            .CFG_W   (CFG_W)
        ) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_i  (cfg_we_i),
            .probe_i (probe_i[c*PROBE_W +: PROBE_W]),
            .op_i    (op_w[c]),
            .codes_i (codes_w[c]),
            .ref_i   (ref_w[c]),
            .match_o (match_w[c])
        );
    end

    trig_combine #(
        .NUM_CMP (NUM_CMP)
    ) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (cfg_we_i),
        .and_mode_i (and_mode_w),
        .match_i    (match_w),
        .trig_o     (trigger_o)
    );

    assert_write_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> !trigger_o);

    assert_write_blanks_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we_i) |=> !trigger_o);

endmodule

// File: tb/probe_trigger_unit_tb.sv
module probe_trigger_unit_tb;

    localparam int NUM_CMP = 2;
    localparam int PROBE_W = 8;
    localparam int CFG_W   = 3 * PROBE_W;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [NUM_CMP*PROBE_W-1:0] probe = '0;
    logic                       cfg_we = 1'b0;
    logic [0:0]                 cfg_idx = '0;
    logic [1:0]                 cfg_kind = '0;
    logic [CFG_W-1:0]           cfg_data = '0;
    logic                       trigger;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    probe_trigger_unit #(.NUM_CMP(NUM_CMP), .PROBE_W(PROBE_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_i    (probe),
        .cfg_we_i   (cfg_we),
        .cfg_idx_i  (cfg_idx),
        .cfg_kind_i (cfg_kind),
        .cfg_data_i (cfg_data),
        .trigger_o  (trigger)
    );

    function automatic logic [CFG_W-1:0] fill(input logic [2:0] c);
        return {PROBE_W{c}};
    endfunction

    function automatic logic [CFG_W-1:0] put(input logic [CFG_W-1:0] v,
                                             input int i, input logic [2:0] c);
        logic [CFG_W-1:0] r;
        r = v;
        r[3*i +: 3] = c;
        return r;
    endfunction

    task automatic check(input logic exp, input string tag);
        checks++;
        if (trigger !== exp) begin
            errors++;
            $display("FAIL %s: trigger=%b expected=%b", tag, trigger, exp);
        end
    endtask

    // Called at a falling edge; one configuration write, then blank check (R8).
    task automatic wr(input int idx, input logic [1:0] kind, input logic [CFG_W-1:0] data);
        cfg_we   = 1'b1;
        cfg_idx  = idx[0:0];
        cfg_kind = kind;
        cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        check(1'b0, "R8 write edge blanks");
    endtask

    // Called at a falling edge; drives probes, checks trigger one edge later (R7).
    task automatic cyc(input logic [7:0] p0, input logic [7:0] p1,
                       input logic exp, input string tag);
        probe = {p1, p0};
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic t_reset();
        check(1'b0, "R9 in reset");
        probe = 16'hFFFF;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(8'h00, 8'h00, 1'b0, "R8 first edge after reset");
        cyc(8'hFF, 8'hFF, 1'b0, "R9 reset operators off");
        cyc(8'h00, 8'h00, 1'b0, "R9 reset operators off");
    endtask

    task automatic t_pattern();
        logic [CFG_W-1:0] c;
        // bits 7..0: X 0 X X 1 0 1 X
        c = fill(3'd2);
        c = put(c, 6, 3'd0);
        c = put(c, 3, 3'd1);
        c = put(c, 2, 3'd0);
        c = put(c, 1, 3'd1);
        c = put(c, 0, 3'd7);
        wr(0, 2'd1, c);
        wr(0, 2'd0, 24'd0);
        cyc(8'hBA, 8'h00, 1'b0, "R8 second edge blanks");
        cyc(8'hBA, 8'h00, 1'b1, "R1 pattern hit");
        cyc(8'h4A, 8'h00, 1'b0, "R1 level-0 bit violated");
        cyc(8'h0B, 8'h00, 1'b1, "R1 don't-care bits free");
        cyc(8'h0E, 8'h00, 1'b0, "R7 miss follows hit by one edge");
    endtask

    task automatic t_edges();
        wr(0, 2'd1, put(fill(3'd2), 0, 3'd3));
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h01, 8'h00, 1'b1, "R2 rise seen");
        cyc(8'h01, 8'h00, 1'b0, "R2 rise held is no rise");
        cyc(8'h00, 8'h00, 1'b0, "R2 fall is no rise");
        wr(0, 2'd1, put(fill(3'd2), 0, 3'd4));
        cyc(8'h01, 8'h00, 1'b0, "R8 blank");
        cyc(8'h00, 8'h00, 1'b1, "R2 fall seen");
        cyc(8'h00, 8'h00, 1'b0, "R2 low held is no fall");
        cyc(8'h01, 8'h00, 1'b0, "R2 rise is no fall");
        wr(0, 2'd1, put(fill(3'd2), 0, 3'd5));
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h01, 8'h00, 1'b1, "R2 either on rise");
        cyc(8'h00, 8'h00, 1'b1, "R2 either on fall");
        cyc(8'h00, 8'h00, 1'b0, "R2 either needs change");
        wr(0, 2'd1, put(fill(3'd2), 0, 3'd6));
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h00, 8'h00, 1'b1, "R2 steady low");
        cyc(8'h01, 8'h00, 1'b0, "R2 steady broken");
        cyc(8'h01, 8'h00, 1'b1, "R2 steady high");
    endtask

    task automatic t_not_equal();
        wr(0, 2'd1, put(put(fill(3'd2), 0, 3'd3), 1, 3'd1));
        wr(0, 2'd0, 24'd1);
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h03, 8'h00, 1'b0, "R3 pattern true gives no match");
        cyc(8'h03, 8'h00, 1'b1, "R3 edge bit failing inverts");
        cyc(8'h02, 8'h00, 1'b1, "R3 pattern false matches");
        cyc(8'h03, 8'h00, 1'b0, "R3 rise again cancels");
    endtask

    task automatic t_magnitude();
        wr(0, 2'd1, fill(3'd0));
        wr(0, 2'd2, 24'd100);
        wr(0, 2'd0, 24'd2);
        cyc(8'd101, 8'h00, 1'b0, "R8 blank");
        cyc(8'd101, 8'h00, 1'b1, "R4 greater above");
        cyc(8'd100, 8'h00, 1'b0, "R4 greater at equal");
        cyc(8'd99,  8'h00, 1'b0, "R4 greater below");
        cyc(8'd200, 8'h00, 1'b1, "R4 greater unsigned");
        wr(0, 2'd0, 24'd3);
        cyc(8'd99,  8'h00, 1'b0, "R8 blank");
        cyc(8'd99,  8'h00, 1'b1, "R4 less below");
        cyc(8'd100, 8'h00, 1'b0, "R4 less at equal");
        cyc(8'd200, 8'h00, 1'b0, "R4 less unsigned");
        wr(0, 2'd0, 24'd4);
        cyc(8'd100, 8'h00, 1'b0, "R8 blank");
        cyc(8'd100, 8'h00, 1'b1, "R4 ge at equal");
        cyc(8'd99,  8'h00, 1'b0, "R4 ge below");
        wr(0, 2'd0, 24'd5);
        cyc(8'd100, 8'h00, 1'b0, "R8 blank");
        cyc(8'd100, 8'h00, 1'b1, "R4 le at equal");
        cyc(8'd101, 8'h00, 1'b0, "R4 le above");
    endtask

    task automatic t_reserved();
        wr(0, 2'd1, fill(3'd2));
        wr(0, 2'd0, 24'd6);
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h00, 8'h00, 1'b0, "R5 code 6 never matches");
        cyc(8'h37, 8'h00, 1'b0, "R5 code 6 never matches");
        wr(0, 2'd0, 24'd7);
        cyc(8'h37, 8'h00, 1'b0, "R8 blank");
        cyc(8'h12, 8'h00, 1'b0, "R5 code 7 never matches");
    endtask

    task automatic t_combine();
        wr(0, 2'd0, 24'd0);
        wr(1, 2'd1, fill(3'd1));
        wr(1, 2'd0, 24'd0);
        cyc(8'h00, 8'h00, 1'b0, "R8 blank");
        cyc(8'h00, 8'h00, 1'b1, "R6 OR one comparator enough");
        cyc(8'h00, 8'hFF, 1'b1, "R10 index routed to comparator 1");
        wr(0, 2'd3, 24'd1);
        cyc(8'h00, 8'hFF, 1'b0, "R8 blank while condition true");
        cyc(8'h00, 8'h00, 1'b0, "R6 AND needs all");
        cyc(8'h00, 8'hFF, 1'b1, "R6 AND all true");
        cyc(8'h00, 8'hFE, 1'b0, "R6 AND one false");
        wr(0, 2'd0, 24'd7);
        cyc(8'h00, 8'hFF, 1'b0, "R8 blank");
        cyc(8'h00, 8'hFF, 1'b0, "R10 write hit only comparator 0");
        wr(1, 2'd3, 24'd0);
        cyc(8'h00, 8'hFF, 1'b0, "R8 blank");
        cyc(8'h00, 8'hFF, 1'b1, "R6 OR comparator 1 alone");
        cyc(8'h00, 8'h00, 1'b0, "R6 OR none true");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_pattern();
        t_edges();
        t_not_equal();
        t_magnitude();
        t_reserved();
        t_combine();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule